// File: doc/BRIEF.md
# Eight-Channel DMA Control and Status Register File

This block is the software-visible register file of an eight-channel DMA controller. A processor reaches it over a plain 32-bit register bus: one write strobe with address and data, and a read-data output that follows the address in the same cycle. Each channel gets a four-bit control nibble that sets its transfer mode and direction. A second word holds the per-channel interrupt enables and self-clearing start bits. A status word shows the sticky completion and error flags next to the live two-bit state of every channel.

The transfer engines sit beside the block. Each engine reads its mode, direction and interrupt enable, and it gets a one-cycle start pulse, plus a one-cycle abort pulse when software turns a busy channel off. Each engine reports its state code and signals completion and failure with single-cycle event strobes. The block latches those events and merges them into one interrupt line for the processor. Two extra words are plain read/write storage, and the remaining slots in the 32-byte window are inert.

Top module: `dma_csr_regs`

## Requirements
- R1: After reset, every readable word reads 0 (status bits [31:16] reflect `ch_state`), and `irq`, `ch_start`, `ch_abort`, `ch_mode`, `ch_dir` and `ch_irq_en` are all 0.
- R2: The control word at address 0x00 holds one nibble per channel at bits [4c+3:4c] and reads back exactly as written. Bits [4c+1:4c] drive `ch_mode[2c+1:2c]` (0 off, 1 descriptor chain, 2 single block). Bit 4c+2 drives `ch_dir[c]` (1 memory to device, 0 device to memory).
- R3: At address 0x08, bits [7:0] are the interrupt enables, bit c driving `ch_irq_en[c]`. A read of 0x08 returns the enables in [7:0] and 0 in [31:8].
- R4: A write to 0x08 with bit 8+c set raises `ch_start[c]` for exactly the one cycle after the write, but only if `ch_state[2c+1:2c]` is 0 (idle) during the write. Otherwise the start is ignored.
- R5: A `ch_done[c]` strobe sets status bit c (the interrupt flag), and the flag stays set until it is cleared.
- R6: A `ch_err[c]` strobe sets both status bit c+8 (the error flag) and status bit c.
- R7: A write to 0x10 clears exactly those flags whose bit is 1 in the write data and leaves the others unchanged. An event that arrives in the same cycle as the clear wins, so the flag stays set.
- R8: Status bits [16+2c+1:16+2c] show `ch_state[2c+1:2c]` with no delay (0 idle, 1 fetching a descriptor, 2 waiting, 3 moving data).
- R9: `irq` is high exactly when some channel has both its interrupt flag and its enable set. It rises in the cycle after the event that sets the flag.
- R10: Addresses 0x04 and 0x14 are independent 32-bit read/write words.
- R11: Addresses 0x0C, 0x18, 0x1C and any unaligned address read 0, and writes to them change no state.
- R12: A write to 0x00 that puts mode 0 in the nibble of a channel whose state is not 0 raises `ch_abort[c]` for exactly the cycle after the write. Idle channels receive no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_state | input | 16 | Two-bit state code per channel |
| ch_done | input | 8 | One-cycle completion event per channel |
| ch_err | input | 8 | One-cycle error event per channel |
| ch_mode | output | 16 | Two-bit mode per channel |
| ch_dir | output | 8 | Direction per channel |
| ch_irq_en | output | 8 | Interrupt enable per channel |
| ch_start | output | 8 | One-cycle start pulse per channel |
| ch_abort | output | 8 | One-cycle abort pulse per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that the engines report events only as single-cycle strobes. They also assume that an engine holds its state code stable around a register write, so the idle test at the write and the pulse that follows refer to the same state. The bench drives `ch_state`, `ch_done` and `ch_err` directly, from the falling edge only, and it changes a state code only between bus accesses, never together with a write to the start or control word. Event strobes that arrive at the same time as a status clear are the one deliberate overlap, since R7 defines the outcome.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    // Word offsets inside the 32-byte register window
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_SCR_A  = 8'h04;
    localparam logic [7:0] OFS_ENABLE = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_SCR_B  = 8'h14;

    // Fixed field placement in the enable and status words
    localparam int START_LSB = 8;
    localparam int ERR_LSB   = 8;
    localparam int STATE_LSB = 16;

    // Per-channel nibble in the control word
    localparam int NIB_W   = 4;
    localparam int DIR_BIT = 2;

    localparam logic [1:0] MODE_OFF = 2'd0;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_FETCH = 2'd1,
        CH_HOLD  = 2'd2,
        CH_MOVE  = 2'd3
    } chan_state_e;

endpackage

// File: rtl/dma_csr_pulse_gen.sv
module dma_csr_pulse_gen #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] start_req,
    input  logic [NUM_CH-1:0] abort_req,
    output logic [NUM_CH-1:0] start_pls,
    output logic [NUM_CH-1:0] abort_pls
);

    typedef struct packed {
        logic [NUM_CH-1:0] start;
        logic [NUM_CH-1:0] abort;
    } pls_t;

    pls_t p_d, p_q;

    // Every pulse lasts one cycle: the next value depends only on this cycle's request
    always_comb begin
        p_d       = p_q;
        p_d.start = start_req;
        p_d.abort = abort_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign start_pls = p_q.start;
    assign abort_pls = p_q.abort;

endmodule

// File: rtl/dma_csr_flags.sv
module dma_csr_flags #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_ev,
    input  logic [NUM_CH-1:0] err_ev,
    input  logic [NUM_CH-1:0] clr_irq,
    input  logic [NUM_CH-1:0] clr_err,
    output logic [NUM_CH-1:0] irq_flag,
    output logic [NUM_CH-1:0] err_flag
);

    typedef struct packed {
        logic [NUM_CH-1:0] irq;
        logic [NUM_CH-1:0] err;
    } flag_t;

    flag_t f_d, f_q;

    // A clear comes first, so an event that arrives in the same cycle survives it
    always_comb begin
        f_d     = f_q;
        f_d.irq = (f_q.irq & ~clr_irq) | done_ev | err_ev;
        f_d.err = (f_q.err & ~clr_err) | err_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign irq_flag = f_q.irq;
    assign err_flag = f_q.err;

endmodule

// File: rtl/dma_csr_irq_comb.sv
module dma_csr_irq_comb #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] irq_flag,
    input  logic [NUM_CH-1:0] irq_en,
    output logic              irq
);

    logic [NUM_CH-1:0] masked;

    always_comb begin
        masked = irq_flag & irq_en;
        irq    = |masked;
    end

endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dma_csr_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [2*NUM_CH-1:0]   ch_state,
    input  logic [NUM_CH-1:0]     ch_done,
    input  logic [NUM_CH-1:0]     ch_err,
    output logic [2*NUM_CH-1:0]   ch_mode,
    output logic [NUM_CH-1:0]     ch_dir,
    output logic [NUM_CH-1:0]     ch_irq_en,
    output logic [NUM_CH-1:0]     ch_start,
    output logic [NUM_CH-1:0]     ch_abort,
    output logic                  irq
);

    localparam int CTRL_W = NIB_W * NUM_CH;

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_SCR_A  = ADDR_W'(OFS_SCR_A);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SCR_B  = ADDR_W'(OFS_SCR_B);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [NUM_CH-1:0] ien;
        logic [DATA_W-1:0] scr_a;
        logic [DATA_W-1:0] scr_b;
    } regs_t;

    regs_t r_d, r_q;

    logic              sel_ctrl, sel_en, sel_stat, sel_sa, sel_sb;
    logic [NUM_CH-1:0] start_req, abort_req;
    logic [NUM_CH-1:0] clr_irq, clr_err;
    logic [NUM_CH-1:0] irq_flag_q, err_flag_q;
    logic [DATA_W-1:0] status_word;

    // Address decode: only exact aligned matches select a word
    always_comb begin
        sel_ctrl = bus_wr && (bus_addr == A_CTRL);
        sel_sa   = bus_wr && (bus_addr == A_SCR_A);
        sel_en   = bus_wr && (bus_addr == A_ENABLE);
        sel_stat = bus_wr && (bus_addr == A_STATUS);
        sel_sb   = bus_wr && (bus_addr == A_SCR_B);
    end

    // Next register values
    always_comb begin
        r_d = r_q;
        if (sel_ctrl) r_d.ctrl  = bus_wdata[CTRL_W-1:0];
        if (sel_en)   r_d.ien   = bus_wdata[NUM_CH-1:0];
        if (sel_sa)   r_d.scr_a = bus_wdata;
        if (sel_sb)   r_d.scr_b = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Per-channel field slicing and pulse requests
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic ch_idle;
        assign ch_idle          = (ch_state[2*c +: 2] == CH_IDLE);
        assign ch_mode[2*c +: 2] = r_q.ctrl[NIB_W*c +: 2];
        assign ch_dir[c]         = r_q.ctrl[NIB_W*c + DIR_BIT];
        assign start_req[c]      = sel_en && bus_wdata[START_LSB + c] && ch_idle;
        assign abort_req[c]      = sel_ctrl && (bus_wdata[NIB_W*c +: 2] == MODE_OFF) && !ch_idle;
    end

    assign ch_irq_en = r_q.ien;

    // Write-one-to-clear masks for the status word
    always_comb begin
        clr_irq = sel_stat ? bus_wdata[NUM_CH-1:0]       : '0;
        clr_err = sel_stat ? bus_wdata[ERR_LSB +: NUM_CH] : '0;
    end

    dma_csr_pulse_gen #(.NUM_CH(NUM_CH)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .abort_req (abort_req),
        .start_pls (ch_start),
        .abort_pls (ch_abort)
    );

    dma_csr_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_ev  (ch_done),
        .err_ev   (ch_err),
        .clr_irq  (clr_irq),
        .clr_err  (clr_err),
        .irq_flag (irq_flag_q),
        .err_flag (err_flag_q)
    );

    dma_csr_irq_comb #(.NUM_CH(NUM_CH)) u_irq (
        .irq_flag (irq_flag_q),
        .irq_en   (r_q.ien),
        .irq      (irq)
    );

    // Status word assembly and read mux
    always_comb begin
        status_word                            = '0;
        status_word[NUM_CH-1:0]                = irq_flag_q;
        status_word[ERR_LSB +: NUM_CH]         = err_flag_q;
        status_word[STATE_LSB +: 2*NUM_CH]     = ch_state;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = DATA_W'(r_q.ctrl);
            A_SCR_A:  bus_rdata = r_q.scr_a;
            A_ENABLE: bus_rdata = DATA_W'(r_q.ien);
            A_STATUS: bus_rdata = status_word;
            A_SCR_B:  bus_rdata = r_q.scr_b;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_csr_regs_chk.sv
module dma_csr_regs_chk #(
    parameter int NUM_CH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [2*NUM_CH-1:0] ch_state,
    input logic [NUM_CH-1:0]   ch_done,
    input logic [2*NUM_CH-1:0] ch_mode,
    input logic [NUM_CH-1:0]   ch_irq_en,
    input logic [NUM_CH-1:0]   ch_start,
    input logic [NUM_CH-1:0]   ch_abort,
    input logic [NUM_CH-1:0]   irq_flag,
    input logic [NUM_CH-1:0]   err_flag,
    input logic                irq
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ck
        // R4: a start pulse only follows a cycle in which the channel was idle
        a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            ch_start[g] |-> ($past(ch_state[2*g +: 2]) == 2'd0))
            else $error("R4 start issued to a busy channel %0d", g);

        // R12: an abort leaves mode 0 behind and targets a channel that was busy
        a_r12_abort_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
            ch_abort[g] |-> (ch_mode[2*g +: 2] == 2'd0) && ($past(ch_state[2*g +: 2]) != 2'd0))
            else $error("R12 abort without mode 0 or on idle channel %0d", g);

        // R6: an error flag never appears without the interrupt flag
        a_r6_err_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(err_flag[g]) |-> irq_flag[g])
            else $error("R6 error flag rose alone on channel %0d", g);

        // R5: with no bus write, a set flag stays set
        a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flag[g] && !bus_wr) |=> irq_flag[g])
            else $error("R5 interrupt flag dropped on channel %0d", g);

        // R9: an enabled completion drives the interrupt line next cycle
        a_r9_irq_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[g] && ch_irq_en[g] && !bus_wr) |=> irq)
            else $error("R9 irq missing after done on channel %0d", g);
    end

endmodule

bind dma_csr_regs dma_csr_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .ch_state  (ch_state),
    .ch_done   (ch_done),
    .ch_mode   (ch_mode),
    .ch_irq_en (ch_irq_en),
    .ch_start  (ch_start),
    .ch_abort  (ch_abort),
    .irq_flag  (irq_flag_q),
    .err_flag  (err_flag_q),
    .irq       (irq)
);

// File: tb/dma_csr_regs_bench.sv
module dma_csr_regs_bench;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] ch_state = '0;
    logic [7:0]  ch_done = '0;
    logic [7:0]  ch_err = '0;
    logic [15:0] ch_mode;
    logic [7:0]  ch_dir, ch_irq_en, ch_start, ch_abort;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_csr_regs #(.NUM_CH(NCH)) u_dma_csr_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_state  (ch_state),
        .ch_done   (ch_done),
        .ch_err    (ch_err),
        .ch_mode   (ch_mode),
        .ch_dir    (ch_dir),
        .ch_irq_en (ch_irq_en),
        .ch_start  (ch_start),
        .ch_abort  (ch_abort),
        .irq       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    // Register access vectors: R2 control, R10 spare words, R11 inert slots, R3 enable word
    localparam vec_t VECS [15] = '{
        '{1'b1, 5'h00, 32'hA6C5_2E91, 4'd2},
        '{1'b0, 5'h00, 32'hA6C5_2E91, 4'd2},
        '{1'b1, 5'h04, 32'hDEAD_BEEF, 4'd10},
        '{1'b1, 5'h14, 32'h1234_5678, 4'd10},
        '{1'b0, 5'h04, 32'hDEAD_BEEF, 4'd10},
        '{1'b0, 5'h14, 32'h1234_5678, 4'd10},
        '{1'b1, 5'h0C, 32'hFFFF_FFFF, 4'd11},
        '{1'b0, 5'h0C, 32'h0000_0000, 4'd11},
        '{1'b1, 5'h18, 32'h0000_FFFF, 4'd11},
        '{1'b0, 5'h18, 32'h0000_0000, 4'd11},
        '{1'b1, 5'h05, 32'h5555_5555, 4'd11},
        '{1'b0, 5'h04, 32'hDEAD_BEEF, 4'd11},
        '{1'b0, 5'h1C, 32'h0000_0000, 4'd11},
        '{1'b1, 5'h08, 32'hFFFF_003C, 4'd3},
        '{1'b0, 5'h08, 32'h0000_003C, 4'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_ev(input logic [7:0] done_m, input logic [7:0] err_m);
        @(negedge clk);
        ch_done = done_m; ch_err = err_m;
        @(negedge clk);
        ch_done = '0; ch_err = '0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog R1..R12 not completed actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h00, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(5'h08, rd); check("R1 enable", rd, 32'h0);
        bus_read(5'h10, rd); check("R1 status", rd, 32'h0);
        check("R1 outputs", {15'h0, irq, ch_start, ch_abort}, 32'h0);
        check("R1 mode/dir", {ch_mode, ch_dir, ch_irq_en}, 32'h0);

        // Vector walk
        foreach (VECS[i]) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
            else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].data);
            end
        end

        // R2 field decoding of A6C5_2E91
        check("R2 ch_mode", {16'h0, ch_mode}, 32'h0000_A1A5);
        check("R2 ch_dir", {24'h0, ch_dir}, 32'h0000_0074);
        check("R3 ch_irq_en", {24'h0, ch_irq_en}, 32'h0000_003C);

        // R4 start on idle channels 0 and 2: one cycle only
        bus_write(5'h08, 32'h0000_053C);
        check("R4 start pulse", {24'h0, ch_start}, 32'h05);
        @(negedge clk);
        check("R4 start cleared", {24'h0, ch_start}, 32'h00);

        // R4 start ignored on busy channel 1
        ch_state = 16'h0008;
        bus_write(5'h08, 32'h0000_063C);
        check("R4 busy ignored", {24'h0, ch_start}, 32'h04);

        // R8 live state readback
        bus_read(5'h10, rd); check("R8 state field", rd, 32'h0008_0000);
        ch_state = 16'h0000;

        // R5 / R9 flag on disabled channel 0, then enabled channel 3
        pulse_ev(8'h01, 8'h00);
        bus_read(5'h10, rd); check("R5 flag ch0", rd, 32'h0000_0001);
        check("R9 masked irq", {31'h0, irq}, 32'h0);
        pulse_ev(8'h08, 8'h00);
        check("R9 irq raised", {31'h0, irq}, 32'h1);
        bus_read(5'h10, rd); check("R5 flags sticky", rd, 32'h0000_0009);

        // R6 error on channel 5
        pulse_ev(8'h00, 8'h20);
        bus_read(5'h10, rd); check("R6 err sets both", rd, 32'h0000_2029);

        // R7 selective clear
        bus_write(5'h10, 32'h0000_2001);
        bus_read(5'h10, rd); check("R7 w1c selective", rd, 32'h0000_0028);
        bus_write(5'h08, 32'h0000_0000);
        check("R9 irq off when disabled", {31'h0, irq}, 32'h0);
        bus_write(5'h08, 32'h0000_003C);
        check("R9 irq back on", {31'h0, irq}, 32'h1);

        // R7 event beats clear in the same cycle
        @(negedge clk);
        ch_done = 8'h01; bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        ch_done = '0; bus_wr = 1'b0;
        bus_read(5'h10, rd); check("R7 event wins", rd, 32'h0000_0029);
        bus_write(5'h10, 32'h0000_FFFF);
        bus_read(5'h10, rd); check("R7 clear all", rd, 32'h0000_0000);
        check("R9 irq low after clear", {31'h0, irq}, 32'h0);

        // R12 abort: ch2 busy with mode 0, ch3 busy keeps mode 1
        ch_state = 16'h0070;
        bus_write(5'h00, 32'h0000_1000);
        check("R12 abort pulse", {24'h0, ch_abort}, 32'h04);
        @(negedge clk);
        check("R12 abort cleared", {24'h0, ch_abort}, 32'h00);
        ch_state = 16'h0000;

        finish_run();
    end

endmodule